// File: doc/BRIEF.md
# GPIO Interrupt and Wake Status Aggregator

This block collects one-cycle event pulses from the pads of a GPIO community and latches them into status words grouped by pad group. Each group has four 32-bit registers: an interrupt status word, an interrupt enable word, a wake status word and a wake enable word. Software reads them back and clears status bits by writing ones. The block drives one registered interrupt line and one registered wake line.

A pad whose host-ownership indication is low belongs to firmware, and its events never reach interrupt status. Its wake status still records events. Wake is raised only for a pad whose wake status and wake enable are both set and that is not steered to the firmware interrupt path. The final group may be partial: bits for pads that do not exist are held at zero.

Top module: `gpio_evt_agg`

## Requirements
- R1: Pad p maps to group word p / GRP_SIZE and to bit p % GRP_SIZE of that word. Byte addresses are as follows: interrupt status at 0x100 + 4·g, interrupt enable at 0x120 + 4·g, wake status at 0x140 + 4·g, and wake enable at 0x160 + 4·g. Reads are combinational on `reg_addr`.
- R2: An event pulse on a host-owned pad sets its interrupt status bit. An event on any pad sets its wake status bit, whatever its ownership.
- R3: A write to a status word clears each bit written as 1. Bits written as 0 keep their value.
- R4: `irq_out` is registered. It is 1 in the cycle after a cycle in which some interrupt status bit and its enable bit are both set, and 0 otherwise.
- R5: An event on a pad whose `host_own` bit is 0 never sets its interrupt status bit.
- R6: `wake_out` is registered. It is 1 in the cycle after a cycle in which some pad has wake status, wake enable and `route_sci` = 0 all at once, and 0 otherwise.
- R7: In every register, bits at or above the pad count of their group read as 0. Writing 1 there has no effect, and those bits never cause `irq_out` or `wake_out` to assert.
- R8: Clearing a pending status bit and then setting its enable raises no interrupt.
- R9: If an event and a write-one-clear hit the same status bit in the same cycle, the bit ends set.
- R10: Reset clears all status and enable words and drives both outputs to 0.
- R11: A write to an address outside the four register regions, or to a group beyond NUM_GRPS, changes nothing. Such an address reads 0.
- R12: Enable words read back what was last written, masked to the existing pads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_event | input | NUM_PADS | One-cycle event pulse per pad |
| host_own | input | NUM_PADS | 1 = pad owned by host, its events may set interrupt status |
| route_sci | input | NUM_PADS | 1 = pad steered to firmware path, its wake is suppressed |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | ADDR_W | Byte address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_out | output | 1 | Registered interrupt line |
| wake_out | output | 1 | Registered wake line |

## Verification
An event or write presented before clock edge k is visible in read data just after edge k. `irq_out` and `wake_out` follow one edge later, at k+1.

The bench presents each stimulus for one cycle. It then parks the address on the register to inspect, with no further events or writes. It samples read data and both lines on the falling edge after k+1. At that point every result is settled and nothing can change it.

Same-cycle event-versus-clear collisions and ownership or routing changes are applied in the stimulus cycle itself. Their effect is judged at the same point.

// File: rtl/gpio_evt_pkg.sv
`timescale 1ns/1ps
package gpio_evt_pkg;

    typedef enum logic [2:0] {
        RK_NONE    = 3'd0,
        RK_INT_STS = 3'd1,
        RK_INT_EN  = 3'd2,
        RK_WK_STS  = 3'd3,
        RK_WK_EN   = 3'd4
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [7:0] grp;
    } reg_sel_t;

    localparam int unsigned INT_STS_BASE = 32'h100;
    localparam int unsigned INT_EN_BASE  = 32'h120;
    localparam int unsigned WK_STS_BASE  = 32'h140;
    localparam int unsigned WK_EN_BASE   = 32'h160;

    function automatic logic [31:0] low_ones(int unsigned n);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < 32; i++) begin
            if (i < int'(n)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_evt_decode.sv
`timescale 1ns/1ps
module gpio_evt_decode
    import gpio_evt_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter int NUM_GRPS = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    localparam int NREG = 4;
    localparam int unsigned SPAN = 4 * NUM_GRPS;
    localparam int unsigned BASES [NREG] = '{INT_STS_BASE, INT_EN_BASE, WK_STS_BASE, WK_EN_BASE};
    localparam reg_kind_e  KINDS [NREG] = '{RK_INT_STS, RK_INT_EN, RK_WK_STS, RK_WK_EN};

    logic [31:0]     off;
    logic [NREG-1:0] hit;
    logic [7:0]      grp_of [NREG];

    assign off = 32'(addr);

    for (genvar k = 0; k < NREG; k++) begin : g_region
        logic [31:0] rel;
        assign rel       = off - BASES[k];
        assign hit[k]    = (off >= BASES[k]) && (off < BASES[k] + SPAN) && (off[1:0] == 2'b00);
        assign grp_of[k] = rel[9:2];
    end

    always_comb begin
        sel.kind = RK_NONE;
        sel.grp  = '0;
        for (int k = 0; k < NREG; k++) begin
            if (hit[k]) begin
                sel.kind = KINDS[k];
                sel.grp  = grp_of[k];
            end
        end
    end
endmodule

// File: rtl/gpio_evt_group.sv
`timescale 1ns/1ps
module gpio_evt_group
    import gpio_evt_pkg::*;
#(
    parameter int GRP_SIZE = 16,
    parameter int VALID    = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [GRP_SIZE-1:0] pad_ev,
    input  logic [GRP_SIZE-1:0] pad_own,
    input  logic [GRP_SIZE-1:0] pad_sci,
    input  logic                wr_int_sts,
    input  logic                wr_int_en,
    input  logic                wr_wk_sts,
    input  logic                wr_wk_en,
    input  logic [31:0]         wdata,
    output logic [31:0]         int_sts,
    output logic [31:0]         int_en,
    output logic [31:0]         wk_sts,
    output logic [31:0]         wk_en,
    output logic                int_hit,
    output logic                wake_hit
);
    localparam logic [31:0] MASK = low_ones(VALID);

    logic [31:0] ev_w, own_w, sci_w;
    logic [31:0] int_clr, wk_clr;

    always_comb begin
        ev_w  = '0;
        own_w = '0;
        sci_w = '0;
        ev_w[GRP_SIZE-1:0]  = pad_ev;
        own_w[GRP_SIZE-1:0] = pad_own;
        sci_w[GRP_SIZE-1:0] = pad_sci;
        int_clr = wr_int_sts ? wdata : '0;
        wk_clr  = wr_wk_sts  ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            int_sts <= '0;
            int_en  <= '0;
            wk_sts  <= '0;
            wk_en   <= '0;
        end else begin
            // a fresh event outranks a same-cycle clear
            int_sts <= ((int_sts & ~int_clr) | (ev_w & own_w)) & MASK;
            wk_sts  <= ((wk_sts & ~wk_clr) | ev_w) & MASK;
            if (wr_int_en) int_en <= wdata & MASK;
            if (wr_wk_en)  wk_en  <= wdata & MASK;
        end
    end

    assign int_hit  = |(int_sts & int_en);
    assign wake_hit = |(wk_sts & wk_en & ~sci_w);
endmodule

// File: rtl/gpio_evt_agg.sv
`timescale 1ns/1ps
module gpio_evt_agg
    import gpio_evt_pkg::*;
#(
    parameter int NUM_PADS = 40,
    parameter int GRP_SIZE = 16,
    parameter int ADDR_W   = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PADS-1:0] pad_event,
    input  logic [NUM_PADS-1:0] host_own,
    input  logic [NUM_PADS-1:0] route_sci,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                irq_out,
    output logic                wake_out
);
    localparam int NUM_GRPS = (NUM_PADS + GRP_SIZE - 1) / GRP_SIZE;
    localparam int PAD_TOT  = NUM_GRPS * GRP_SIZE;

    logic [PAD_TOT-1:0] ev_p, own_p, sci_p;
    logic [NUM_GRPS-1:0][31:0] int_sts_w, int_en_w, gpe_sts_w, gpe_en_w;
    logic [NUM_GRPS-1:0] int_hit, wake_hit;
    reg_sel_t sel;

    always_comb begin
        ev_p  = '0;
        own_p = '0;
        sci_p = '0;
        ev_p[NUM_PADS-1:0]  = pad_event;
        own_p[NUM_PADS-1:0] = host_own;
        sci_p[NUM_PADS-1:0] = route_sci;
    end

    gpio_evt_decode #(.ADDR_W(ADDR_W), .NUM_GRPS(NUM_GRPS)) u_dec (
        .addr (reg_addr),
        .sel  (sel)
    );

    for (genvar g = 0; g < NUM_GRPS; g++) begin : g_grp
        localparam int REM   = NUM_PADS - g * GRP_SIZE;
        localparam int VALID = (REM > GRP_SIZE) ? GRP_SIZE : REM;
        logic here;
        assign here = reg_wr && (sel.grp == 8'(g));

        gpio_evt_group #(.GRP_SIZE(GRP_SIZE), .VALID(VALID)) u_grp (
            .clk        (clk),
            .rst        (rst),
            .pad_ev     (ev_p [g*GRP_SIZE +: GRP_SIZE]),
            .pad_own    (own_p[g*GRP_SIZE +: GRP_SIZE]),
            .pad_sci    (sci_p[g*GRP_SIZE +: GRP_SIZE]),
            .wr_int_sts (here && sel.kind == RK_INT_STS),
            .wr_int_en  (here && sel.kind == RK_INT_EN),
            .wr_wk_sts  (here && sel.kind == RK_WK_STS),
            .wr_wk_en   (here && sel.kind == RK_WK_EN),
            .wdata      (reg_wdata),
            .int_sts    (int_sts_w[g]),
            .int_en     (int_en_w[g]),
            .wk_sts     (gpe_sts_w[g]),
            .wk_en      (gpe_en_w[g]),
            .int_hit    (int_hit[g]),
            .wake_hit   (wake_hit[g])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int g = 0; g < NUM_GRPS; g++) begin
            if (sel.grp == 8'(g)) begin
                unique case (sel.kind)
                    RK_INT_STS: reg_rdata = int_sts_w[g];
                    RK_INT_EN:  reg_rdata = int_en_w[g];
                    RK_WK_STS:  reg_rdata = gpe_sts_w[g];
                    RK_WK_EN:   reg_rdata = gpe_en_w[g];
                    default:    reg_rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_out  <= 1'b0;
            wake_out <= 1'b0;
        end else begin
            irq_out  <= |int_hit;
            wake_out <= |wake_hit;
        end
    end
endmodule

// File: rtl/gpio_evt_agg_chk.sv
`timescale 1ns/1ps
module gpio_evt_agg_chk
    import gpio_evt_pkg::*;
#(
    parameter int NUM_PADS = 40,
    parameter int GRP_SIZE = 16,
    parameter int ADDR_W   = 9,
    parameter int NUM_GRPS = 3
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NUM_PADS-1:0]       pad_event,
    input logic [NUM_PADS-1:0]       host_own,
    input logic [NUM_PADS-1:0]       route_sci,
    input logic                      reg_wr,
    input logic [ADDR_W-1:0]         reg_addr,
    input logic [31:0]               reg_wdata,
    input logic                      irq_out,
    input logic                      wake_out,
    input logic [NUM_GRPS-1:0][31:0] int_sts_w,
    input logic [NUM_GRPS-1:0][31:0] int_en_w,
    input logic [NUM_GRPS-1:0][31:0] gpe_sts_w,
    input logic [NUM_GRPS-1:0][31:0] gpe_en_w
);
    localparam int LAST_N = NUM_PADS - (NUM_GRPS - 1) * GRP_SIZE;
    localparam logic [31:0] LAST_MASK = low_ones(LAST_N);

    logic any_int, any_wake;
    logic [31:0] sci_g [NUM_GRPS];

    always_comb begin
        any_int  = 1'b0;
        any_wake = 1'b0;
        for (int g = 0; g < NUM_GRPS; g++) begin
            sci_g[g] = '0;
            for (int b = 0; b < GRP_SIZE; b++) begin
                if (g * GRP_SIZE + b < NUM_PADS) sci_g[g][b] = route_sci[g * GRP_SIZE + b];
            end
            any_int  = any_int  | (|(int_sts_w[g] & int_en_w[g]));
            any_wake = any_wake | (|(gpe_sts_w[g] & gpe_en_w[g] & ~sci_g[g]));
        end
    end

    assert_irq_follows_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_out == $past(any_int)));

    assert_wake_follows_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (wake_out == $past(any_wake)));

    assert_tail_zero_R7: assert property (@(posedge clk) disable iff (rst)
        ((int_sts_w[NUM_GRPS-1] | int_en_w[NUM_GRPS-1] | gpe_sts_w[NUM_GRPS-1]
          | gpe_en_w[NUM_GRPS-1]) & ~LAST_MASK) == 32'd0);

    assert_reset_clears_R10: assert property (@(posedge clk)
        rst |=> (int_en_w == '0 && gpe_en_w == '0 && int_sts_w == '0 && !irq_out && !wake_out));

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        localparam int G = p / GRP_SIZE;
        localparam int B = p % GRP_SIZE;
        localparam int unsigned STS_ADDR = INT_STS_BASE + 4 * G;

        assert_foreign_pad_R5: assert property (@(posedge clk) disable iff (rst)
            (!host_own[p] && !int_sts_w[G][B]) |=> !int_sts_w[G][B]);

        assert_event_wins_R9: assert property (@(posedge clk) disable iff (rst)
            (pad_event[p] && host_own[p]) |=> int_sts_w[G][B]);

        assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
            (reg_wr && reg_addr == ADDR_W'(STS_ADDR) && reg_wdata[B]
             && !(pad_event[p] && host_own[p])) |=> !int_sts_w[G][B]);
    end
endmodule

bind gpio_evt_agg gpio_evt_agg_chk #(
    .NUM_PADS(NUM_PADS), .GRP_SIZE(GRP_SIZE), .ADDR_W(ADDR_W), .NUM_GRPS(NUM_GRPS)
) u_chk (.*);

// File: tb/gpio_evt_agg_bench.sv
`timescale 1ns/1ps
module gpio_evt_agg_bench;
    localparam int NP = 40;
    localparam logic [39:0] ALL   = 40'hFF_FFFF_FFFF;
    localparam logic [39:0] NONE  = 40'h0;
    localparam logic [39:0] P20   = 40'h00_0010_0000;
    localparam logic [39:0] NO20  = 40'hFF_FFEF_FFFF;
    localparam logic [39:0] P39   = 40'h80_0000_0000;

    typedef struct packed {
        logic [7:0]  req;
        logic [39:0] ev;
        logic [39:0] own;
        logic [39:0] sci;
        logic        wr;
        logic [8:0]  addr;
        logic [31:0] wd;
        logic [8:0]  raddr;
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic        exp_wake;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{8'd2,  40'h8, ALL, NONE, 1'b0, 9'h000, 32'h0,        9'h100, 32'h8,  1'b0, 1'b0}, // R2 owned pad sets
        '{8'd4,  NONE,  ALL, NONE, 1'b1, 9'h120, 32'h8,        9'h120, 32'h8,  1'b1, 1'b0}, // R4 enable raises irq
        '{8'd3,  NONE,  ALL, NONE, 1'b1, 9'h100, 32'h8,        9'h100, 32'h0,  1'b0, 1'b0}, // R3 clear
        '{8'd5,  P20,   NO20,NONE, 1'b0, 9'h000, 32'h0,        9'h104, 32'h0,  1'b0, 1'b0}, // R5 foreign pad
        '{8'd2,  NONE,  ALL, NONE, 1'b0, 9'h000, 32'h0,        9'h144, 32'h10, 1'b0, 1'b0}, // R2 wake sts anyway
        '{8'd6,  NONE,  ALL, P20,  1'b1, 9'h164, 32'h10,       9'h164, 32'h10, 1'b0, 1'b0}, // R6 routed: no wake
        '{8'd6,  NONE,  ALL, NONE, 1'b0, 9'h000, 32'h0,        9'h144, 32'h10, 1'b0, 1'b1}, // R6 wake
        '{8'd3,  NONE,  ALL, NONE, 1'b1, 9'h144, 32'h10,       9'h144, 32'h0,  1'b0, 1'b0}, // R3 wake clear
        '{8'd1,  P39,   ALL, NONE, 1'b0, 9'h000, 32'h0,        9'h108, 32'h80, 1'b0, 1'b0}, // R1 last pad
        '{8'd7,  NONE,  ALL, NONE, 1'b1, 9'h128, 32'hFFFFFFFF, 9'h128, 32'hFF, 1'b1, 1'b0}, // R7 masked enable
        '{8'd3,  NONE,  ALL, NONE, 1'b1, 9'h108, 32'hFFFFFF7F, 9'h108, 32'h80, 1'b1, 1'b0}, // R3 zero keeps
        '{8'd9,  P39,   ALL, NONE, 1'b1, 9'h108, 32'h80,       9'h108, 32'h80, 1'b1, 1'b0}, // R9 event wins
        '{8'd3,  NONE,  ALL, NONE, 1'b1, 9'h108, 32'h80,       9'h108, 32'h0,  1'b0, 1'b0}, // R3 clear
        '{8'd11, NONE,  ALL, NONE, 1'b1, 9'h10C, 32'hFFFFFFFF, 9'h10C, 32'h0,  1'b0, 1'b0}, // R11 no group 3
        '{8'd1,  40'h01_0001_0001, ALL, NONE, 1'b0, 9'h000, 32'h0, 9'h100, 32'h1, 1'b1, 1'b0}, // R1 multi
        '{8'd1,  NONE,  ALL, NONE, 1'b0, 9'h000, 32'h0,        9'h104, 32'h1,  1'b1, 1'b0}, // R1 group 1
        '{8'd12, NONE,  ALL, NONE, 1'b1, 9'h160, 32'h5,        9'h160, 32'h5,  1'b1, 1'b1}, // R12 readback
        '{8'd7,  NONE,  ALL, NONE, 1'b0, 9'h000, 32'h0,        9'h148, 32'h81, 1'b1, 1'b1}  // R7 last word
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pad_event = '0;
    logic [NP-1:0] host_own  = '0;
    logic [NP-1:0] route_sci = '0;
    logic          reg_wr    = 1'b0;
    logic [8:0]    reg_addr  = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq_out, wake_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    gpio_evt_agg u_gpio_evt_agg (
        .clk(clk), .rst(rst), .pad_event(pad_event), .host_own(host_own),
        .route_sci(route_sci), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out), .wake_out(wake_out)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [39:0] ev, input logic [39:0] own, input logic [39:0] sci,
                         input logic wr, input logic [8:0] addr, input logic [31:0] wd,
                         input logic [8:0] raddr);
        @(negedge clk);
        pad_event = ev; host_own = own; route_sci = sci;
        reg_wr = wr; reg_addr = addr; reg_wdata = wd;
        @(negedge clk);
        pad_event = '0; reg_wr = 1'b0; reg_addr = raddr;
        @(negedge clk);
    endtask

    task automatic expect3(input string req, input logic [31:0] rd, input logic irq, input logic wk);
        chk(req, "rdata", reg_rdata, rd);
        chk(req, "irq", 32'(irq_out), 32'(irq));
        chk(req, "wake", 32'(wake_out), 32'(wk));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        apply(NONE, ALL, NONE, 1'b0, 9'h0, 32'h0, 9'h120);
        expect3("R10", 32'h0, 1'b0, 1'b0);
        apply(NONE, ALL, NONE, 1'b0, 9'h0, 32'h0, 9'h100);
        expect3("R10", 32'h0, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i].ev, TBL[i].own, TBL[i].sci, TBL[i].wr, TBL[i].addr, TBL[i].wd, TBL[i].raddr);
            expect3($sformatf("R%0d vec%0d", TBL[i].req, i), TBL[i].exp_rd, TBL[i].exp_irq, TBL[i].exp_wake);
        end

        // clear all status, then stale-event scenario (R8)
        apply(NONE, ALL, NONE, 1'b1, 9'h100, 32'hFFFFFFFF, 9'h100);
        apply(NONE, ALL, NONE, 1'b1, 9'h104, 32'hFFFFFFFF, 9'h104);
        apply(NONE, ALL, NONE, 1'b1, 9'h108, 32'hFFFFFFFF, 9'h108);
        apply(NONE, ALL, NONE, 1'b1, 9'h140, 32'hFFFFFFFF, 9'h140);
        expect3("R3", 32'h0, 1'b0, 1'b0);
        apply(40'h20, ALL, NONE, 1'b0, 9'h0, 32'h0, 9'h100);
        expect3("R8", 32'h20, 1'b0, 1'b0);
        apply(NONE, ALL, NONE, 1'b1, 9'h100, 32'h20, 9'h100);
        expect3("R8", 32'h0, 1'b0, 1'b0);
        apply(NONE, ALL, NONE, 1'b1, 9'h120, 32'h28, 9'h120);
        expect3("R8", 32'h28, 1'b0, 1'b0);
        apply(NONE, ALL, NONE, 1'b0, 9'h0, 32'h0, 9'h100);
        expect3("R8", 32'h0, 1'b0, 1'b0);

        // mid-run reset (R10)
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        apply(NONE, ALL, NONE, 1'b0, 9'h0, 32'h0, 9'h128);
        expect3("R10", 32'h0, 1'b0, 1'b0);
        apply(NONE, ALL, NONE, 1'b0, 9'h0, 32'h0, 9'h160);
        expect3("R10", 32'h0, 1'b0, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule